// File: doc/BRIEF.md
# Standby and Output Mode Gate

This block is the last stage in front of the pins of a camera sensor timing generator. Pulse generators elsewhere produce the sensor drive clocks, the sample-and-hold strobes, the delay-line clocks, the clamp pulses and a group of slower frame-level signals. This block passes them on. Depending on the configuration inputs, it forces some of them to fixed levels or freezes them.

Two configuration inputs, a processing-mode select and a test select, pick one of three operating modes: analog colour, digital colour 1 or digital colour 2. In analog mode the two shared clamp pins drive the clamp-2 and clamp-3 pulses. In either digital mode the block releases those pins and reads them as standby controls. A low level on the first shared pin requests standby. In standby the fast drive group goes low and the frame-level group holds its last value. The second shared pin decides whether the pixel clock keeps toggling during standby.

Top module: `out_mode_gate`

## Requirements
- R1: The mode is decoded from (proc_mode, test_sel). (0,0) is analog, (1,0) is digital 1 and (1,1) is digital 2. The combination (0,1) acts as analog and raises mode_err, which is low in every other combination.
- R2: In analog mode, outside standby, every pulse input appears unchanged on its output. Both pad_oe bits are 1, pad_out[0] carries clp2_in and pad_out[1] carries clp3_in.
- R3: In both digital modes pad_oe is 2'b00 and pad_out is 2'b00.
- R4: In digital 1, outside standby, sep_out is all ones, sw_out is all zeros and dl_out is 2'b01 (bit 0 high, bit 1 low). fast_out, hold_out and pix_clk_out follow their inputs.
- R5: In digital 2, outside standby, sep_out and sw_out follow their inputs and dl_out is 2'b01.
- R6: At a clock edge where the mode is digital and pad_in[0] is 0, standby begins. From that edge on, fast_out, sep_out, sw_out and dl_out are all zero. Standby ends at the first edge where that condition is false.
- R7: hold_out holds the value hold_in had at the edge where standby began. It follows hold_in again from the first edge at which standby ends.
- R8: During standby, pix_clk_out follows pix_clk_in if pad_in[1] was 1 at the last edge and is 0 otherwise. Outside standby it always follows pix_clk_in.
- R9: In analog mode, including the (0,1) case, pad_in has no effect on any output.
- R10: While rst_n is low and after its release, the block is out of standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| proc_mode | input | 1 | Processing-mode select (1 = digital) |
| test_sel | input | 1 | Test select, picks digital 2 when proc_mode is 1 |
| fast_in | input | FAST_W | Sensor, drive, reset-gate and data sample pulses |
| sep_in | input | 2 | Colour-separation sample pulses |
| sw_in | input | 2 | Switching sample pulses |
| dl_in | input | 2 | Delay-line clocks |
| hold_in | input | HOLD_W | Frame-level signals frozen in standby |
| pix_clk_in | input | 1 | Pixel clock |
| clp2_in | input | 1 | Clamp-2 pulse for the first shared pin |
| clp3_in | input | 1 | Clamp-3 pulse for the second shared pin |
| pad_in | input | 2 | Levels read from the shared pins |
| fast_out | output | FAST_W | Gated fast pulses |
| sep_out | output | 2 | Gated colour-separation pulses |
| sw_out | output | 2 | Gated switching pulses |
| dl_out | output | 2 | Gated delay-line clocks |
| hold_out | output | HOLD_W | Frame-level signals, frozen in standby |
| pix_clk_out | output | 1 | Gated pixel clock |
| pad_out | output | 2 | Drive values for the shared pins |
| pad_oe | output | 2 | Output enables for the shared pins |
| mode_err | output | 1 | Unsupported mode combination |

## Verification
The assertions assume that proc_mode, test_sel and pad_in are stable around each rising edge. The standby decision is taken from their values at that edge. The bench changes every input only on the falling edge. Mode changes happen only between test phases, while the pulse inputs take fresh random values every cycle. The freeze and release properties therefore compare against a settled value and never against a mid-cycle transition.

// File: rtl/out_mode_gate.sv
module out_mode_gate #(
  parameter int FAST_W = 13,
  parameter int HOLD_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              proc_mode,
  input  logic              test_sel,
  input  logic [FAST_W-1:0] fast_in,
  input  logic [1:0]        sep_in,
  input  logic [1:0]        sw_in,
  input  logic [1:0]        dl_in,
  input  logic [HOLD_W-1:0] hold_in,
  input  logic              pix_clk_in,
  input  logic              clp2_in,
  input  logic              clp3_in,
  input  logic [1:0]        pad_in,
  output logic [FAST_W-1:0] fast_out,
  output logic [1:0]        sep_out,
  output logic [1:0]        sw_out,
  output logic [1:0]        dl_out,
  output logic [HOLD_W-1:0] hold_out,
  output logic              pix_clk_out,
  output logic [1:0]        pad_out,
  output logic [1:0]        pad_oe,
  output logic              mode_err
);

  logic digital, dig1, stby_req;
  logic stby_q, keep_q;
  logic [HOLD_W-1:0] hold_q;

  assign digital  = proc_mode;
  assign dig1     = proc_mode & ~test_sel;
  assign mode_err = ~proc_mode & test_sel;
  assign stby_req = digital & ~pad_in[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stby_q <= 1'b0;
      keep_q <= 1'b0;
      hold_q <= '0;
    end else begin
      stby_q <= stby_req;
      keep_q <= pad_in[1];
      if (!stby_q) hold_q <= hold_in;
    end
  end

  assign pad_oe  = digital ? 2'b00 : 2'b11;
  assign pad_out = digital ? 2'b00 : {clp3_in, clp2_in};

  assign fast_out    = stby_q ? '0 : fast_in;
  assign sep_out     = stby_q ? 2'b00 : (dig1 ? 2'b11 : sep_in);
  assign sw_out      = stby_q ? 2'b00 : (dig1 ? 2'b00 : sw_in);
  assign dl_out      = stby_q ? 2'b00 : (digital ? 2'b01 : dl_in);
  assign hold_out    = stby_q ? hold_q : hold_in;
  assign pix_clk_out = (stby_q & ~keep_q) ? 1'b0 : pix_clk_in;

endmodule

module out_mode_gate_chk #(
  parameter int FAST_W = 13,
  parameter int HOLD_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              proc_mode,
  input logic              test_sel,
  input logic [1:0]        pad_in,
  input logic [1:0]        pad_oe,
  input logic [FAST_W-1:0] fast_out,
  input logic [1:0]        sep_out,
  input logic [1:0]        sw_out,
  input logic [1:0]        dl_out,
  input logic [HOLD_W-1:0] hold_out,
  input logic              pix_clk_out,
  input logic              mode_err,
  input logic              stby_q,
  input logic              keep_q
);

  assert_err_drives_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> (pad_oe == 2'b11));

  assert_dig_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    proc_mode |-> (pad_oe == 2'b00));

  assert_dig1_levels_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_mode && !test_sel && !stby_q) |-> (sep_out == 2'b11 && sw_out == 2'b00 && dl_out == 2'b01));

  assert_stby_enter_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_mode && !pad_in[0]) |=> (fast_out == '0 && sep_out == 2'b00 && sw_out == 2'b00 && dl_out == 2'b00));

  assert_hold_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_q && $past(stby_q)) |-> $stable(hold_out));

  assert_pix_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_q && !keep_q) |-> !pix_clk_out);

  assert_analog_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !proc_mode |=> !stby_q);

endmodule

bind out_mode_gate out_mode_gate_chk #(.FAST_W(FAST_W), .HOLD_W(HOLD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .proc_mode(proc_mode), .test_sel(test_sel),
  .pad_in(pad_in), .pad_oe(pad_oe), .fast_out(fast_out), .sep_out(sep_out),
  .sw_out(sw_out), .dl_out(dl_out), .hold_out(hold_out),
  .pix_clk_out(pix_clk_out), .mode_err(mode_err), .stby_q(stby_q), .keep_q(keep_q)
);

// File: tb/tb_out_mode_gate.sv
`timescale 1ns/1ps
module tb_out_mode_gate;
  localparam int FW = 13;
  localparam int HW = 7;

  logic clk = 0, rst_n = 0;
  logic pm = 0, ts = 0;
  logic [FW-1:0] fast_in = '0;
  logic [1:0] sep_in = 0, sw_in = 0, dl_in = 0, pad_in = 0;
  logic [HW-1:0] hold_in = '0;
  logic pix_in = 0, c2 = 0, c3 = 0;
  logic [FW-1:0] fast_out;
  logic [1:0] sep_out, sw_out, dl_out, pad_out, pad_oe;
  logic [HW-1:0] hold_out;
  logic pix_out, err;

  int checks = 0, failures = 0;
  bit m_stby = 0, m_keep = 0;
  logic [HW-1:0] m_hold = '0;
  string tag = "R10";

  always #10 clk = ~clk;

  out_mode_gate #(.FAST_W(FW), .HOLD_W(HW)) dut (
    .clk(clk), .rst_n(rst_n), .proc_mode(pm), .test_sel(ts),
    .fast_in(fast_in), .sep_in(sep_in), .sw_in(sw_in), .dl_in(dl_in),
    .hold_in(hold_in), .pix_clk_in(pix_in), .clp2_in(c2), .clp3_in(c3),
    .pad_in(pad_in), .fast_out(fast_out), .sep_out(sep_out), .sw_out(sw_out),
    .dl_out(dl_out), .hold_out(hold_out), .pix_clk_out(pix_out),
    .pad_out(pad_out), .pad_oe(pad_oe), .mode_err(err));

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stby <= 0; m_keep <= 0; m_hold <= '0;
    end else begin
      if (!m_stby) m_hold <= hold_in;
      m_stby <= pm && !pad_in[0];
      m_keep <= pad_in[1];
    end
  end

  task automatic compare();
    logic [FW-1:0] e_fast;
    logic [1:0] e_sep, e_sw, e_dl, e_po, e_oe;
    logic [HW-1:0] e_hold;
    logic e_pix, e_err;
    e_err = !pm && ts;
    e_oe  = pm ? 2'b00 : 2'b11;
    e_po  = pm ? 2'b00 : {c3, c2};
    if (m_stby) begin
      e_fast = '0; e_sep = 0; e_sw = 0; e_dl = 0;
      e_hold = m_hold; e_pix = m_keep ? pix_in : 1'b0;
    end else begin
      e_fast = fast_in; e_hold = hold_in; e_pix = pix_in;
      e_sep = (pm && !ts) ? 2'b11 : sep_in;
      e_sw  = (pm && !ts) ? 2'b00 : sw_in;
      e_dl  = pm ? 2'b01 : dl_in;
    end
    checks++;
    if ({fast_out, sep_out, sw_out, dl_out, hold_out, pix_out, pad_out, pad_oe, err} !==
        {e_fast, e_sep, e_sw, e_dl, e_hold, e_pix, e_po, e_oe, e_err}) begin
      failures++;
      $display("FAIL %s t=%0t act fast=%h sep=%b sw=%b dl=%b hold=%h pix=%b po=%b oe=%b err=%b exp fast=%h sep=%b sw=%b dl=%b hold=%h pix=%b po=%b oe=%b err=%b",
        tag, $time, fast_out, sep_out, sw_out, dl_out, hold_out, pix_out, pad_out, pad_oe, err,
        e_fast, e_sep, e_sw, e_dl, e_hold, e_pix, e_po, e_oe, e_err);
    end
  endtask

  task automatic run(input int n, input bit p, input bit t, input logic [1:0] pads, input string tg);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tag = tg; pm = p; ts = t; pad_in = pads;
      fast_in = FW'($urandom); sep_in = 2'($urandom); sw_in = 2'($urandom);
      dl_in = 2'($urandom); hold_in = HW'($urandom); pix_in = 1'($urandom);
      c2 = 1'($urandom); c3 = 1'($urandom);
      #5 compare();
    end
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    run(3, 0, 0, 2'b00, "R10");
    @(negedge clk); rst_n = 1;
    run(3, 0, 0, 2'b00, "R10");
    run(20, 0, 0, 2'b11, "R2");
    run(10, 0, 1, 2'b11, "R1");
    run(10, 0, 1, 2'b00, "R9");
    run(15, 0, 0, 2'b00, "R9");
    run(20, 1, 0, 2'b11, "R4");
    run(20, 1, 1, 2'b11, "R5");
    run(5,  1, 1, 2'b10, "R3");
    run(15, 1, 0, 2'b00, "R6");
    run(3,  1, 0, 2'b11, "R7");
    run(15, 1, 1, 2'b10, "R8");
    run(12, 1, 1, 2'b00, "R8");
    run(5,  0, 0, 2'b00, "R7");
    run(8,  1, 0, 2'b00, "R6");
    @(negedge clk); rst_n = 0;
    #5 compare();
    run(4, 1, 0, 2'b00, "R10");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule